// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Edge Capture Interrupts

This block is a general-purpose I/O peripheral serving up to 32 lines. A host reaches four 32-bit registers through a simple word-indexed read/write port. Each line has three per-line controls: an output value, a drive-enable (direction) bit and an interrupt enable bit. A fourth register reports which lines have seen a qualifying event. The pins appear as three separate vectors: sampled input, driven output and output enable. The pad buffers sit outside the block.

Every input passes through a two-stage synchronizer before software can read it or the event detector can see it. The kind of event that counts as an interrupt is fixed when the block is built. The build can choose rising edges, falling edges, both edges or a high level. No register changes that choice at run time. All lines that are enabled and flagged are combined into a single registered interrupt output.

Top module: `mmio_gpio_ctrl`

## Requirements
- R1: After synchronous reset, every line is an input (`pin_oe` = 0), `pin_out` is 0, all enable bits are 0, all flag bits are clear, `irq` is 0 and `reg_rdata` is 0.
- R2: Word index 1 holds the direction bits. Bit n = 1 drives line n as an output, so `pin_oe[n]` follows it. Reading index 1 returns the stored value.
- R3: A write to word index 0 sets `pin_out`. A read of index 0 returns `pin_in` after it has passed through the two-flop synchronizer, whatever the direction setting.
- R4: Word index 2 holds the interrupt enable bits, where 1 = enabled. Reading index 2 returns the stored value.
- R5: In the edge build modes, an input transition of the configured polarity sets bit n of word index 3. The bit then stays set while the input keeps changing. In the both-edges mode, a falling transition also sets it.
- R6: In the edge build modes, writing 1 to bit n of word index 3 clears that bit, and writing 0 leaves it unchanged.
- R7: In the level-high build mode, word index 3 reads as the synchronized input level, and writes to it have no effect.
- R8: `irq` is a registered OR, over all lines, of the flag bit ANDed with the enable bit. A flagged line whose enable bit is 0 does not raise `irq`.
- R9: Register bits at or above the configured line count read as 0, and writes to them are dropped.
- R10: `reg_rdata` is loaded on the clock edge where `reg_rd` is high and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word index: 0 data, 1 direction, 2 enable, 3 flags |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| pin_in | input | NLINES | Sampled line levels from the pads |
| pin_out | output | NLINES | Output values toward the pads |
| pin_oe | output | NLINES | Per-line drive enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds one instance in both-edges mode and one in level mode, each with 12 lines, so the unused upper register bits get exercised. In the first instance it checks three things: a falling transition sets a flag, a zero write leaves a flag alone, and a one write clears it. A design that used the wrong polarity would leave the flag clear, and a design that cleared on any write would drop it. It also confirms that a flagged but disabled line keeps `irq` low, which a design without masking would violate. In the level instance, a write that tries to clear the flags must not change them, and `irq` must follow the pin level. The bench also checks that a read result stays put after a later write, which catches a read path that is not registered.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int BUS_W = 32;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_MASK = 2'd2,
        SEL_CAP  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } bus_req_t;

    function automatic reg_sel_e decode_sel(input logic [1:0] idx);
        return reg_sel_e'(idx);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |=> q == $past(stage1_q)); // R3
endmodule

// File: rtl/gpio_edge_cap.sv
module gpio_edge_cap
    import gpio_pkg::*;
#(
    parameter int    W    = 16,
    parameter trig_e TRIG = TRIG_RISE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] clr,
    output logic [W-1:0] cap
);
    generate
        if (TRIG == TRIG_LEVEL) begin : g_level
            logic unused_clr;
            assign unused_clr = ^clr;
            assign cap = lvl;
        end else begin : g_edge
            logic [W-1:0] prev_q;
            logic [W-1:0] cap_q;
            logic [W-1:0] hit;

            always_comb begin
                case (TRIG)
                    TRIG_RISE: hit = lvl & ~prev_q;
                    TRIG_FALL: hit = ~lvl & prev_q;
                    default:   hit = lvl ^ prev_q;
                endcase
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= '0;
                    cap_q  <= '0;
                end else begin
                    prev_q <= lvl;
                    cap_q  <= (cap_q & ~clr) | hit;
                end
            end

            assign cap = cap_q;

            AST_CAP_STICKY: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> ((cap_q & ($past(cap_q) & ~$past(clr))) ==
                          ($past(cap_q) & ~$past(clr)))); // R5
            AST_CAP_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
                ($past(clr) == '0) |-> ((cap_q | ~$past(cap_q)) == '1)); // R6
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic [W-1:0]     wdata,
    input  logic [W-1:0]     sync_in,
    input  logic [W-1:0]     cap,
    output logic [W-1:0]     dout,
    output logic [W-1:0]     dir,
    output logic [W-1:0]     mask,
    output logic [BUS_W-1:0] rdata
);
    logic [W-1:0]     dout_q, dir_q, mask_q;
    logic [BUS_W-1:0] rd_word;
    logic [BUS_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else if (req.wr) begin
            case (req.sel)
                SEL_DATA: dout_q <= wdata;
                SEL_DIR:  dir_q  <= wdata;
                SEL_MASK: mask_q <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rd_word = '0;
        case (req.sel)
            SEL_DATA: rd_word[W-1:0] = sync_in;
            SEL_DIR:  rd_word[W-1:0] = dir_q;
            SEL_MASK: rd_word[W-1:0] = mask_q;
            default:  rd_word[W-1:0] = cap;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (req.rd) rdata_q <= rd_word;
    end

    assign dout  = dout_q;
    assign dir   = dir_q;
    assign mask  = mask_q;
    assign rdata = rdata_q;

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dir_q == '0 && mask_q == '0 && dout_q == '0 && rdata_q == '0)); // R1
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(req.rd) && !$past(rst) |-> $stable(rdata_q)); // R10
endmodule

// File: rtl/mmio_gpio_ctrl.sv
module mmio_gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int    NLINES = 16,
    parameter trig_e TRIG   = TRIG_RISE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NLINES-1:0] pin_in,
    output logic [NLINES-1:0] pin_out,
    output logic [NLINES-1:0] pin_oe,
    output logic              irq
);
    bus_req_t          req;
    logic [NLINES-1:0] wdata_l;
    logic [NLINES-1:0] sync_lvl;
    logic [NLINES-1:0] cap;
    logic [NLINES-1:0] clr;
    logic [NLINES-1:0] mask;
    logic              irq_q;

    assign req.wr  = reg_wr;
    assign req.rd  = reg_rd;
    assign req.sel = decode_sel(reg_addr);
    assign wdata_l = reg_wdata[NLINES-1:0];

    generate
        if (NLINES < BUS_W) begin : g_hi_unused
            logic unused_hi;
            assign unused_hi = ^reg_wdata[BUS_W-1:NLINES];
        end
    endgenerate

    assign clr = (req.wr && req.sel == SEL_CAP) ? wdata_l : '0;

    gpio_sync #(.W(NLINES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (sync_lvl)
    );

    gpio_edge_cap #(.W(NLINES), .TRIG(TRIG)) u_cap (
        .clk (clk),
        .rst (rst),
        .lvl (sync_lvl),
        .clr (clr),
        .cap (cap)
    );

    gpio_regs #(.W(NLINES)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .wdata   (wdata_l),
        .sync_in (sync_lvl),
        .cap     (cap),
        .dout    (pin_out),
        .dir     (pin_oe),
        .mask    (mask),
        .rdata   (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(cap & mask);
    end

    assign irq = irq_q;

    AST_IRQ_NEEDS_ENABLED_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(|(cap & mask))); // R8
    AST_OE_FOLLOWS_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd1) |=> pin_oe == $past(reg_wdata[NLINES-1:0])); // R2
endmodule

// File: tb/mmio_gpio_ctrl_tb_top.sv
module mmio_gpio_ctrl_tb_top;
    import gpio_pkg::*;

    localparam int N = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_a = 1'b0, rd_a = 1'b0, wr_b = 1'b0, rd_b = 1'b0;
    logic [1:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata_a, rdata_b;
    logic [N-1:0]  pin_a = '0, pin_b = '0;
    logic [N-1:0]  out_a, oe_a, out_b, oe_b;
    logic          irq_a, irq_b;
    int            n_checks = 0;
    int            n_errors = 0;

    always #5 clk = ~clk;

    mmio_gpio_ctrl #(.NLINES(N), .TRIG(TRIG_BOTH)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(wr_a), .reg_rd(rd_a), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata_a), .pin_in(pin_a),
        .pin_out(out_a), .pin_oe(oe_a), .irq(irq_a));

    mmio_gpio_ctrl #(.NLINES(N), .TRIG(TRIG_LEVEL)) dut_lvl_i (
        .clk(clk), .rst(rst), .reg_wr(wr_b), .reg_rd(rd_b), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata_b), .pin_in(pin_b),
        .pin_out(out_b), .pin_oe(oe_b), .irq(irq_b));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input bit lvl, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (lvl) wr_b = 1'b1; else wr_a = 1'b1;
        @(negedge clk);
        wr_a = 1'b0; wr_b = 1'b0;
    endtask

    task automatic bus_read(input bit lvl, input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        if (lvl) rd_b = 1'b1; else rd_a = 1'b1;
        @(negedge clk);
        rd_a = 1'b0; rd_b = 1'b0;
        d = lvl ? rdata_b : rdata_a;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {31'd0, irq_a}, 32'd0);
        check("R1 pin_oe", {20'd0, oe_a}, 32'd0);
        check("R1 pin_out", {20'd0, out_a}, 32'd0);
        check("R1 rdata", rdata_a, 32'd0);
        bus_read(0, 2'd2, v); check("R1 enable reg", v, 32'd0);
        bus_read(0, 2'd3, v); check("R1 flag reg", v, 32'd0);
    endtask

    task automatic t_dir_data();
        logic [31:0] v;
        bus_write(0, 2'd1, 32'h0000_00F0);
        check("R2 pin_oe", {20'd0, oe_a}, 32'h0F0);
        bus_read(0, 2'd1, v); check("R2 dir readback", v, 32'h0F0);
        bus_write(0, 2'd0, 32'hFFFF_F123);
        check("R3 pin_out", {20'd0, out_a}, 32'h123);
        bus_write(0, 2'd1, 32'hFFFF_FFFF);
        bus_read(0, 2'd1, v); check("R9 upper dir bits", v, 32'h0000_0FFF);
        check("R10 rdata before write", rdata_a, 32'h0000_0FFF);
        bus_write(0, 2'd1, 32'h0);
        check("R10 rdata holds", rdata_a, 32'h0000_0FFF);
        bus_write(0, 2'd2, 32'hFFFF_F00C);
        bus_read(0, 2'd2, v); check("R4 R9 enable readback", v, 32'h0000_000C);
        bus_write(0, 2'd2, 32'h0);
    endtask

    task automatic t_pins_and_flags();
        logic [31:0] v;
        pin_a = 12'h5A5;
        settle();
        bus_read(0, 2'd0, v); check("R3 data readback", v, 32'h5A5);
        bus_write(0, 2'd3, 32'hFFFF_FFFF);
        bus_read(0, 2'd3, v); check("R6 clear all", v, 32'h0);
        pin_a = 12'h5AD;
        settle();
        bus_read(0, 2'd3, v); check("R5 rising flag", v, 32'h008);
        pin_a = 12'h5A5;
        settle();
        bus_read(0, 2'd3, v); check("R5 sticky", v, 32'h008);
        bus_write(0, 2'd3, 32'h0);
        bus_read(0, 2'd3, v); check("R6 zero write keeps", v, 32'h008);
        bus_write(0, 2'd3, 32'h008);
        bus_read(0, 2'd3, v); check("R6 one write clears", v, 32'h0);
        pin_a = 12'h5A4;
        settle();
        bus_read(0, 2'd3, v); check("R5 falling flag both mode", v, 32'h001);
        check("R8 masked stays low", {31'd0, irq_a}, 32'd0);
        bus_write(0, 2'd2, 32'h001);
        settle();
        check("R8 enabled raises irq", {31'd0, irq_a}, 32'd1);
        bus_write(0, 2'd3, 32'h001);
        settle();
        check("R8 irq drops after clear", {31'd0, irq_a}, 32'd0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        pin_b = 12'h004;
        settle();
        bus_read(1, 2'd3, v); check("R7 level reads pin", v, 32'h004);
        bus_write(1, 2'd3, 32'hFFF);
        bus_read(1, 2'd3, v); check("R7 write ignored", v, 32'h004);
        check("R8 level masked low", {31'd0, irq_b}, 32'd0);
        bus_write(1, 2'd2, 32'h004);
        settle();
        check("R8 level irq high", {31'd0, irq_b}, 32'd1);
        pin_b = 12'h000;
        settle();
        bus_read(1, 2'd3, v); check("R7 level follows low", v, 32'h0);
        check("R8 level irq low", {31'd0, irq_b}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_dir_data();
        t_pins_and_flags();
        t_level();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule